// File: doc/BRIEF.md
# Two-Cluster Register File with Rationed Cross-Path

This block holds the general registers of a wide-issue datapath split into two clusters, A and B. Each cluster owns a bank of sixteen 32-bit registers. Each cluster serves four functional-unit ports, and every port has two source operands and one write port. A unit commits results only into the bank of its own cluster. It reads its own bank freely on both sources. It can take an operand from the other cluster's bank only through the single cross-path that belongs to its cluster.

Each source carries a cross-select flag. When the flag is set, that operand is fetched from the opposite bank over the cluster's cross-path. The cross-path carries one operand per cycle, so the block arbitrates the requests of a cluster and raises a conflict flag when more than one source asks for it. The block also flags two ports of one cluster that write the same register in the same cycle. Decode, the functional units and memory sit outside. The block only supplies operands, commits writes and reports conflicts.

Top module: `rfx_regfile`

## Requirements
- R1: While rst_n is low, every register of both banks is cleared to zero, and any read after reset returns zero until the register is written.
- R2: A source with its cross-select flag low returns, combinationally, the register of its own cluster's bank that its address selects. Source k of a cluster belongs to port k/2, operand k%2, and its address and data occupy slice k of the flattened source buses.
- R3: A write commits at the rising clock edge. A read of a register that is being written in the same cycle returns the old value, and the new value is visible from the next cycle.
- R4: Writes from cluster A ports change only bank A, and writes from cluster B ports change only bank B.
- R5: A source with its cross-select flag high that wins arbitration returns the register of the opposite cluster's bank that its address selects.
- R6: A cluster's cross-conflict output is high in exactly those cycles in which more than one of its sources has its cross-select flag set.
- R7: When several sources of a cluster request the cross-path, only the one with the lowest source index is served, and every other requesting source returns zero.
- R8: A cluster's write-collision output is high in exactly those cycles in which two or more enabled write ports of that cluster target the same register.
- R9: When several ports of a cluster write the same register in one cycle, the data of the highest-numbered of those ports is stored.
- R10: Both cross-paths operate in the same cycle independently, so that two cross reads, one in each direction, are served together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr_en | input | 4 | Write enable of each cluster A port |
| a_wr_addr | input | 16 | Write register index, 4 bits per cluster A port |
| a_wr_data | input | 128 | Write data, 32 bits per cluster A port |
| a_src_addr | input | 32 | Source register index, 4 bits per cluster A source |
| a_src_xsel | input | 8 | Cross-select flag per cluster A source |
| a_src_data | output | 256 | Operand, 32 bits per cluster A source |
| b_wr_en | input | 4 | Write enable of each cluster B port |
| b_wr_addr | input | 16 | Write register index, 4 bits per cluster B port |
| b_wr_data | input | 128 | Write data, 32 bits per cluster B port |
| b_src_addr | input | 32 | Source register index, 4 bits per cluster B source |
| b_src_xsel | input | 8 | Cross-select flag per cluster B source |
| b_src_data | output | 256 | Operand, 32 bits per cluster B source |
| a_xconflict | output | 1 | More than one cluster A source requests the cross-path |
| b_xconflict | output | 1 | More than one cluster B source requests the cross-path |
| a_wcollide | output | 1 | Two cluster A writes target one register |
| b_wcollide | output | 1 | Two cluster B writes target one register |

## Verification
The bench fills one bank while it reads the other. A design that leaked writes across clusters would then show non-zero values in the untouched bank. Every pair of cross requests within a cluster is tried, which catches an arbiter that favours the higher index, serves two requests, or passes stale data to a loser instead of zero. Every pair of write ports is driven onto a single register. A reversed priority shows up there as the lower port's data in the next read. Reads of a register in the cycle it is written expose any accidental bypass. A random phase then mixes all of these against a behavioural model of both banks.

// File: rtl/rfx_pkg.sv
package rfx_pkg;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_NUM_REGS = 16;
  localparam int unsigned DEF_NUM_FU   = 4;
  localparam int unsigned CLUSTERS     = 2;
  localparam int unsigned SRC_PER_FU   = 2;

  // flat source index of operand s of port p
  function automatic int unsigned src_index(input int unsigned p, input int unsigned s);
    return p * SRC_PER_FU + s;
  endfunction
endpackage

// File: rtl/rfx_bank.sv
module rfx_bank #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned NUM_WP   = 4,
  parameter int unsigned NUM_RP   = 9,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_WP-1:0] wr_en,
  input  logic [ADDR_W-1:0] wr_addr [NUM_WP],
  input  logic [DATA_W-1:0] wr_data [NUM_WP],
  input  logic [ADDR_W-1:0] rd_addr [NUM_RP],
  output logic [DATA_W-1:0] rd_data [NUM_RP]
);
  logic [DATA_W-1:0]   reg_q [NUM_REGS];
  logic [DATA_W-1:0]   reg_d [NUM_REGS];
  logic [NUM_REGS-1:0] reg_ce;

  // next state: ascending port order, so the highest port writing a register wins
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      reg_d[r]  = reg_q[r];
      reg_ce[r] = 1'b0;
      for (int p = 0; p < NUM_WP; p++) begin
        if (wr_en[p] && (wr_addr[p] == ADDR_W'(r))) begin
          reg_d[r]  = wr_data[p];
          reg_ce[r] = 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[g] <= '0;
      end else if (reg_ce[g]) begin
        reg_q[g] <= reg_d[g];
      end
    end
  end

  // combinational read, no bypass of same-cycle writes
  for (genvar k = 0; k < NUM_RP; k++) begin : g_rd
    assign rd_data[k] = reg_q[rd_addr[k]];
  end
endmodule

// File: rtl/rfx_xarb.sv
module rfx_xarb #(
  parameter int unsigned NUM_REQ = 8
) (
  input  logic [NUM_REQ-1:0] req,
  output logic [NUM_REQ-1:0] gnt,
  output logic               conflict
);
  logic       found;
  logic [1:0] seen;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    seen  = 2'd0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (req[i]) begin
        if (!found) begin
          gnt[i] = 1'b1;
          found  = 1'b1;
        end
        if (seen != 2'd2) begin
          seen = seen + 2'd1;
        end
      end
    end
    conflict = (seen == 2'd2);
  end
endmodule

// File: rtl/rfx_wcoll.sv
module rfx_wcoll #(
  parameter int unsigned NUM_WP = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic [NUM_WP-1:0] wr_en,
  input  logic [ADDR_W-1:0] wr_addr [NUM_WP],
  output logic              collide
);
  always_comb begin
    collide = 1'b0;
    for (int i = 0; i < NUM_WP; i++) begin
      for (int j = i + 1; j < NUM_WP; j++) begin
        if (wr_en[i] && wr_en[j] && (wr_addr[i] == wr_addr[j])) begin
          collide = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rfx_regfile.sv
module rfx_regfile
  import rfx_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  parameter int unsigned NUM_FU   = DEF_NUM_FU,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS),
  localparam int unsigned NUM_SRC = NUM_FU * SRC_PER_FU
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_FU-1:0]         a_wr_en,
  input  logic [NUM_FU*ADDR_W-1:0]  a_wr_addr,
  input  logic [NUM_FU*DATA_W-1:0]  a_wr_data,
  input  logic [NUM_SRC*ADDR_W-1:0] a_src_addr,
  input  logic [NUM_SRC-1:0]        a_src_xsel,
  output logic [NUM_SRC*DATA_W-1:0] a_src_data,
  input  logic [NUM_FU-1:0]         b_wr_en,
  input  logic [NUM_FU*ADDR_W-1:0]  b_wr_addr,
  input  logic [NUM_FU*DATA_W-1:0]  b_wr_data,
  input  logic [NUM_SRC*ADDR_W-1:0] b_src_addr,
  input  logic [NUM_SRC-1:0]        b_src_xsel,
  output logic [NUM_SRC*DATA_W-1:0] b_src_data,
  output logic                      a_xconflict,
  output logic                      b_xconflict,
  output logic                      a_wcollide,
  output logic                      b_wcollide
);
  localparam int unsigned NUM_RP = NUM_SRC + 1;  // local sources plus one cross read

  // cluster-indexed views of the port buses (0 = A, 1 = B)
  logic [CLUSTERS-1:0][NUM_FU-1:0]         cl_wen;
  logic [CLUSTERS-1:0][NUM_FU*ADDR_W-1:0]  cl_waddr;
  logic [CLUSTERS-1:0][NUM_FU*DATA_W-1:0]  cl_wdata;
  logic [CLUSTERS-1:0][NUM_SRC*ADDR_W-1:0] cl_saddr;
  logic [CLUSTERS-1:0][NUM_SRC-1:0]        cl_sxsel;
  logic [CLUSTERS-1:0][NUM_SRC*DATA_W-1:0] cl_sdata;
  logic [CLUSTERS-1:0]                     cl_xconf;
  logic [CLUSTERS-1:0]                     cl_wcoll;
  // cross-path: address requested by cluster c, data delivered to cluster c
  logic [CLUSTERS-1:0][ADDR_W-1:0]         x_addr;
  logic [CLUSTERS-1:0][DATA_W-1:0]         x_data;

  assign cl_wen[0]   = a_wr_en;
  assign cl_wen[1]   = b_wr_en;
  assign cl_waddr[0] = a_wr_addr;
  assign cl_waddr[1] = b_wr_addr;
  assign cl_wdata[0] = a_wr_data;
  assign cl_wdata[1] = b_wr_data;
  assign cl_saddr[0] = a_src_addr;
  assign cl_saddr[1] = b_src_addr;
  assign cl_sxsel[0] = a_src_xsel;
  assign cl_sxsel[1] = b_src_xsel;
  assign a_src_data  = cl_sdata[0];
  assign b_src_data  = cl_sdata[1];
  assign a_xconflict = cl_xconf[0];
  assign b_xconflict = cl_xconf[1];
  assign a_wcollide  = cl_wcoll[0];
  assign b_wcollide  = cl_wcoll[1];

  for (genvar c = 0; c < CLUSTERS; c++) begin : g_cl
    localparam int unsigned OC = CLUSTERS - 1 - c;

    logic [ADDR_W-1:0]  wa    [NUM_FU];
    logic [DATA_W-1:0]  wd    [NUM_FU];
    logic [ADDR_W-1:0]  ra    [NUM_RP];
    logic [DATA_W-1:0]  rd    [NUM_RP];
    logic [NUM_SRC-1:0] gnt;
    logic [ADDR_W-1:0]  xa_sel;
    logic [NUM_SRC*DATA_W-1:0] sdata;

    for (genvar p = 0; p < NUM_FU; p++) begin : g_wp
      assign wa[p] = cl_waddr[c][p*ADDR_W +: ADDR_W];
      assign wd[p] = cl_wdata[c][p*DATA_W +: DATA_W];
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_rp
      assign ra[k] = cl_saddr[c][k*ADDR_W +: ADDR_W];
    end
    // last read port of this bank serves the opposite cluster's cross-path
    assign ra[NUM_SRC] = x_addr[OC];
    assign x_data[OC]  = rd[NUM_SRC];

    rfx_bank #(
      .DATA_W  (DATA_W),
      .NUM_REGS(NUM_REGS),
      .NUM_WP  (NUM_FU),
      .NUM_RP  (NUM_RP)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cl_wen[c]),
      .wr_addr(wa),
      .wr_data(wd),
      .rd_addr(ra),
      .rd_data(rd)
    );

    rfx_xarb #(
      .NUM_REQ(NUM_SRC)
    ) u_xarb (
      .req     (cl_sxsel[c]),
      .gnt     (gnt),
      .conflict(cl_xconf[c])
    );

    rfx_wcoll #(
      .NUM_WP(NUM_FU),
      .ADDR_W(ADDR_W)
    ) u_wcoll (
      .wr_en  (cl_wen[c]),
      .wr_addr(wa),
      .collide(cl_wcoll[c])
    );

    // address of the granted cross request (one-hot grant)
    always_comb begin
      xa_sel = '0;
      for (int k = 0; k < NUM_SRC; k++) begin
        if (gnt[k]) begin
          xa_sel = xa_sel | ra[k];
        end
      end
    end
    assign x_addr[c] = xa_sel;

    // operand steering: local, served cross, or zero for a refused cross request
    always_comb begin
      for (int k = 0; k < NUM_SRC; k++) begin
        if (!cl_sxsel[c][k]) begin
          sdata[k*DATA_W +: DATA_W] = rd[k];
        end else if (gnt[k]) begin
          sdata[k*DATA_W +: DATA_W] = x_data[c];
        end else begin
          sdata[k*DATA_W +: DATA_W] = '0;
        end
      end
    end
    assign cl_sdata[c] = sdata;
  end
endmodule

// File: rtl/rfx_regfile_chk.sv
module rfx_regfile_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_FU = 4,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned NUM_SRC = NUM_FU * 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_FU-1:0]         a_wr_en,
  input logic [NUM_FU*ADDR_W-1:0]  a_wr_addr,
  input logic [NUM_FU*DATA_W-1:0]  a_wr_data,
  input logic [NUM_SRC*ADDR_W-1:0] a_src_addr,
  input logic [NUM_SRC-1:0]        a_src_xsel,
  input logic [NUM_SRC*DATA_W-1:0] a_src_data,
  input logic [NUM_FU-1:0]         b_wr_en,
  input logic [NUM_SRC*ADDR_W-1:0] b_src_addr,
  input logic [NUM_SRC-1:0]        b_src_xsel,
  input logic [NUM_SRC*DATA_W-1:0] b_src_data,
  input logic                      a_xconflict,
  input logic                      b_xconflict,
  input logic                      a_wcollide
);
  localparam int unsigned TOPP = NUM_FU - 1;

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
    end
  end

  AST_XCONF_A: assert property (@(posedge clk) disable iff (!rst_n)
    a_xconflict == ($countones(a_src_xsel) > 1)); // R6
  AST_XCONF_B: assert property (@(posedge clk) disable iff (!rst_n)
    b_xconflict == ($countones(b_src_xsel) > 1)); // R6

  for (genvar i = 1; i < NUM_SRC; i++) begin : g_loser
    localparam logic [NUM_SRC-1:0] LOWER = NUM_SRC'((1 << i) - 1);
    AST_LOSER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (a_src_xsel[i] && ((a_src_xsel & LOWER) != '0)) |-> (a_src_data[i*DATA_W +: DATA_W] == '0)); // R7
  end

  AST_WCOLL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr_en[0] && a_wr_en[1] && (a_wr_addr[0 +: ADDR_W] == a_wr_addr[ADDR_W +: ADDR_W])) |-> a_wcollide); // R8

  AST_TOP_PORT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(a_wr_en[TOPP]) && !a_src_xsel[0] &&
     (a_src_addr[0 +: ADDR_W] == $past(a_wr_addr[TOPP*ADDR_W +: ADDR_W])))
    |-> (a_src_data[0 +: DATA_W] == $past(a_wr_data[TOPP*DATA_W +: DATA_W]))); // R9

  AST_BANK_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ($past(b_wr_en) == '0) && $stable(b_src_addr) &&
     (b_src_xsel == '0) && ($past(b_src_xsel) == '0)) |-> $stable(b_src_data)); // R4
endmodule

bind rfx_regfile rfx_regfile_chk #(
  .DATA_W(DATA_W),
  .NUM_FU(NUM_FU),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .a_wr_en    (a_wr_en),
  .a_wr_addr  (a_wr_addr),
  .a_wr_data  (a_wr_data),
  .a_src_addr (a_src_addr),
  .a_src_xsel (a_src_xsel),
  .a_src_data (a_src_data),
  .b_wr_en    (b_wr_en),
  .b_src_addr (b_src_addr),
  .b_src_xsel (b_src_xsel),
  .b_src_data (b_src_data),
  .a_xconflict(a_xconflict),
  .b_xconflict(b_xconflict),
  .a_wcollide (a_wcollide)
);

// File: tb/rfx_regfile_test.sv
`timescale 1ns/1ps
module rfx_regfile_test;
  localparam int NF = 4;
  localparam int NS = 8;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NR = 16;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic [NF-1:0] wen [2];
  logic [AW-1:0] wa  [2][NF];
  logic [DW-1:0] wd  [2][NF];
  logic [AW-1:0] sa  [2][NS];
  logic [NS-1:0] sx  [2];
  logic [DW-1:0] mdl [2][NR];

  logic [NF*AW-1:0] a_wr_addr, b_wr_addr;
  logic [NF*DW-1:0] a_wr_data, b_wr_data;
  logic [NS*AW-1:0] a_src_addr, b_src_addr;
  logic [NS*DW-1:0] a_src_data, b_src_data;
  logic a_xconflict, b_xconflict, a_wcollide, b_wcollide;

  always_comb begin
    for (int p = 0; p < NF; p++) begin
      a_wr_addr[p*AW +: AW] = wa[0][p];
      b_wr_addr[p*AW +: AW] = wa[1][p];
      a_wr_data[p*DW +: DW] = wd[0][p];
      b_wr_data[p*DW +: DW] = wd[1][p];
    end
    for (int k = 0; k < NS; k++) begin
      a_src_addr[k*AW +: AW] = sa[0][k];
      b_src_addr[k*AW +: AW] = sa[1][k];
    end
  end

  rfx_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .a_wr_en(wen[0]), .a_wr_addr(a_wr_addr), .a_wr_data(a_wr_data),
    .a_src_addr(a_src_addr), .a_src_xsel(sx[0]), .a_src_data(a_src_data),
    .b_wr_en(wen[1]), .b_wr_addr(b_wr_addr), .b_wr_data(b_wr_data),
    .b_src_addr(b_src_addr), .b_src_xsel(sx[1]), .b_src_data(b_src_data),
    .a_xconflict(a_xconflict), .b_xconflict(b_xconflict),
    .a_wcollide(a_wcollide), .b_wcollide(b_wcollide)
  );

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic clear_stim();
    for (int c = 0; c < 2; c++) begin
      wen[c] = '0;
      sx[c]  = '0;
      for (int p = 0; p < NF; p++) begin wa[c][p] = '0; wd[c][p] = '0; end
      for (int k = 0; k < NS; k++) sa[c][k] = '0;
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < NR; r++) mdl[c][r] = '0;
  endtask

  // one cycle: check combinational outputs at the falling edge, then commit
  task automatic step(input string ph);
    logic [DW-1:0] nxt [2][NR];
    logic [DW-1:0] exp_d, act_d;
    int lo, cnt;
    bit coll;
    string tag;
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      lo = -1; cnt = 0;
      for (int k = 0; k < NS; k++) if (sx[c][k]) begin cnt++; if (lo < 0) lo = k; end
      for (int k = 0; k < NS; k++) begin
        if (!sx[c][k]) begin exp_d = mdl[c][sa[c][k]]; tag = "R2"; end
        else if (k == lo) begin exp_d = mdl[1-c][sa[c][k]]; tag = "R5"; end
        else begin exp_d = '0; tag = "R7"; end
        act_d = (c == 0) ? a_src_data[k*DW +: DW] : b_src_data[k*DW +: DW];
        chk(act_d === exp_d, {ph, " ", tag}, $sformatf("cluster %0d source %0d", c, k), act_d, exp_d);
      end
      act_d = DW'((c == 0) ? a_xconflict : b_xconflict);
      chk(act_d === DW'(cnt > 1), {ph, " R6"}, $sformatf("cluster %0d xconflict", c), act_d, DW'(cnt > 1));
      coll = 1'b0;
      for (int i = 0; i < NF; i++)
        for (int j = i + 1; j < NF; j++)
          if (wen[c][i] && wen[c][j] && wa[c][i] == wa[c][j]) coll = 1'b1;
      act_d = DW'((c == 0) ? a_wcollide : b_wcollide);
      chk(act_d === DW'(coll), {ph, " R8"}, $sformatf("cluster %0d wcollide", c), act_d, DW'(coll));
    end
    for (int c = 0; c < 2; c++) begin
      for (int r = 0; r < NR; r++) nxt[c][r] = mdl[c][r];
      for (int p = 0; p < NF; p++) if (wen[c][p]) nxt[c][wa[c][p]] = wd[c][p];
    end
    @(posedge clk);
    #1;
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < NR; r++) mdl[c][r] = nxt[c][r];
    clear_stim();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    @(posedge clk);
    #1;
  endtask

  task automatic read_sweep(input string ph);
    for (int r = 0; r < NR; r++) begin
      for (int c = 0; c < 2; c++)
        for (int k = 0; k < NS; k++) sa[c][k] = AW'(r + k);
      step(ph);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clear_stim();
    model_clear();
    do_reset();
    read_sweep("R1 reset state");

    // fill one cluster while reading the other; same-cycle read sees old value
    for (int c = 0; c < 2; c++) begin
      for (int r = 0; r < NR; r++) begin
        wen[c][r % NF] = 1'b1;
        wa[c][r % NF]  = AW'(r);
        wd[c][r % NF]  = 32'h5A00_0000 ^ (c << 20) ^ (r * 32'h0103_0507);
        for (int k = 0; k < NS; k++) begin sa[0][k] = AW'(r); sa[1][k] = AW'(r); end
        step("R3 R4 fill");
      end
    end
    read_sweep("R2 R3 readback");

    // single cross request per cluster from every source and address
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < NS; k++)
        for (int r = 0; r < NR; r++) begin
          sx[c] = NS'(1 << k);
          for (int m = 0; m < NS; m++) sa[c][m] = AW'(r + m);
          step("R5 single");
        end

    // both cross-paths together
    for (int k = 0; k < NS; k++)
      for (int r = 0; r < NR; r += 3) begin
        sx[0] = NS'(1 << k);
        sx[1] = NS'(1 << (NS - 1 - k));
        for (int m = 0; m < NS; m++) begin sa[0][m] = AW'(r + m); sa[1][m] = AW'(r + 2 * m); end
        step("R10 dual");
      end

    // every pair of cross requests in one cluster
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < NS; i++)
        for (int j = i + 1; j < NS; j++) begin
          sx[c] = NS'((1 << i) | (1 << j));
          for (int m = 0; m < NS; m++) sa[c][m] = AW'(m + j);
          step("R6 R7 pair");
        end

    // every pair of write ports on one register, then read it back
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < NF; p++)
        for (int q = p + 1; q < NF; q++) begin
          wen[c][p] = 1'b1; wen[c][q] = 1'b1;
          wa[c][p] = AW'(p + q + c); wa[c][q] = AW'(p + q + c);
          wd[c][p] = 32'h1111_0000 + p; wd[c][q] = 32'hEEEE_0000 + q;
          step("R8 R9 collide");
          for (int m = 0; m < NS; m++) sa[c][m] = AW'(p + q + c);
          step("R9 readback");
        end

    // random mix
    for (int n = 0; n < 3000; n++) begin
      for (int c = 0; c < 2; c++) begin
        for (int p = 0; p < NF; p++) begin
          wen[c][p] = ($urandom % 3) == 0;
          wa[c][p]  = AW'($urandom);
          wd[c][p]  = $urandom;
        end
        for (int k = 0; k < NS; k++) begin
          sa[c][k] = AW'($urandom);
          sx[c][k] = ($urandom % 6) == 0;
        end
      end
      step("R2 R3 R4 R5 R9 R10 random");
    end

    do_reset();
    read_sweep("R1 mid-run reset");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule